// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

The block produces a set of clock outputs for a system board and can stop them without ever producing a shortened pulse. Every clock is modelled as a registered level in one master clock domain. A CPU-rate divider and a PCI-rate divider are built from counters in that domain. A group of CPU outputs and a group of gated PCI outputs can each be stopped by their own active-low stop input. One free-running PCI output and one auxiliary output ignore the group stops.

An active-low power-down input brings every output to a low park, each only after its current pulse has finished. When power-down is released, a wake counter must expire before any output restarts. The auxiliary output runs at full or half rate. The rate is chosen by a strap pin that is read once, just after reset.

All stop decisions are synchronized through two flops that advance on the target clock's rising boundaries. The gate enable that follows them changes only in the cycle where its clock is about to rise from low. This gives a latency of 2 to 3 cycles of the controlled clock, counted from the stop or start input to the first affected pulse.

Top module: `clkstop_ctrl`

## Requirements
- R1: After reset is released, every clock output and both status outputs stay low until the wake delay of WAKE_CYCLES master cycles has elapsed.
- R2: While running, all N_CPU CPU outputs carry one identical waveform: high for CPU_HALF master cycles, then low for CPU_HALF master cycles.
- R3: After cpu_stop_n goes low, the CPU outputs produce exactly two more complete high pulses and then stay low. cpu_running then reads 0.
- R4: After cpu_stop_n returns high, the first CPU rising edge comes between 2 and 3 CPU periods later, measured in master cycles. That first high phase lasts a full CPU_HALF cycles.
- R5: The gated PCI outputs rise only together with a rise of pci_free. After pci_stop_n goes low they produce exactly two more complete pulses and then stay low. After pci_stop_n returns high they restart between 2 and 3 PCI periods later.
- R6: pci_free keeps toggling with PCI_HALF high and PCI_HALF low while pci_stop_n is low. cpu_stop_n and pci_stop_n do not affect each other's group.
- R7: While pwr_dn_n is low, every output is held low, including pci_free and aux_clk. The CPU outputs still complete at least one pulse after pwr_dn_n falls, rather than stopping at once.
- R8: After pwr_dn_n returns high, every output stays low for at least WAKE_CYCLES master cycles. The CPU outputs then restart within WAKE_CYCLES + 3 CPU periods + 4 cycles, at full rate.
- R9: When strap_half is 0 at the first cycle after reset, aux_clk runs high and low for AUX_HALF cycles each. When it is 1, aux_clk runs high and low for 2*AUX_HALF cycles each. Later changes of strap_half have no effect until the next reset.
- R10: Every high phase of a CPU, gated PCI or free PCI output lasts exactly its half period. Every low phase lasts at least its half period.
- R11: cpu_running and pci_running are 1 while their group's enable is set. When one of them is 0, that group's outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Active-low stop for the CPU group (asynchronous) |
| pci_stop_n | input | 1 | Active-low stop for the gated PCI group (asynchronous) |
| pwr_dn_n | input | 1 | Active-low power-down for all outputs (asynchronous) |
| strap_half | input | 1 | Auxiliary rate strap, read once after reset: 1 selects half rate |
| cpu_clk | output | N_CPU | Gated CPU clocks |
| pci_clk | output | N_PCI | Gated PCI clocks |
| pci_free | output | 1 | PCI clock not affected by pci_stop_n |
| aux_clk | output | 1 | Auxiliary clock, full or half rate |
| cpu_running | output | 1 | CPU group enable status |
| pci_running | output | 1 | Gated PCI group enable status |

## Verification
The bench drives each stop input halfway between edges and counts the pulses that follow. A gate that updated its enable in the middle of a high phase would leave a shortened pulse, or a pulse count other than two. Restart timing is measured against the 2 to 3 period window. A restart missing a synchronizer stage would come early, and a first phase that started anywhere other than a low-to-high boundary would be short. Power-down checks that the free PCI and auxiliary outputs are held low too, and that the wake wait is respected. The strap is flipped after sampling to show that a design which keeps reading the pin would change the auxiliary rate.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Per-output-group enable pipeline: two sync stages and the live enable.
  typedef struct packed {
    logic s1;
    logic s2;
    logic en;
  } gate_st_t;

endpackage

// File: rtl/clkstop_div.sv
module clkstop_div #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] half_m1,
  output logic          phase_nx,
  output logic          rise_tick
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;
  logic          flip;

  always_comb begin
    flip    = run && (cnt_q == half_m1);
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!run) begin
      cnt_d   = '0;
      phase_d = 1'b0;
    end else if (flip) begin
      cnt_d   = '0;
      phase_d = ~phase_q;
    end else begin
      cnt_d   = cnt_q + 1'b1;
    end
  end

  assign phase_nx  = phase_d;
  assign rise_tick = flip && !phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
  import clkstop_pkg::*;
#(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise_tick,
  input  logic         phase_nx,
  input  logic         run,
  output logic [N-1:0] clk_o,
  output logic         running
);

  gate_st_t st_q, st_d;
  logic     out_q, out_d;

  // The pipeline moves only on the cycle where the clock is about to go
  // high, so the enable never changes inside a phase.
  always_comb begin
    st_d = st_q;
    if (rise_tick) begin
      st_d.s1 = run;
      st_d.s2 = st_q.s1;
      st_d.en = st_q.s2;
    end
    out_d = phase_nx && st_d.en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      out_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      out_q <= out_d;
    end
  end

  for (genvar b = 0; b < N; b++) begin : g_out
    assign clk_o[b] = out_q;
  end

  assign running = st_q.en;

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int N_CPU       = 4,
  parameter int N_PCI       = 7,
  parameter int CPU_HALF    = 2,
  parameter int PCI_HALF    = 6,
  parameter int AUX_HALF    = 3,
  parameter int WAKE_CYCLES = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_stop_n,
  input  logic             pci_stop_n,
  input  logic             pwr_dn_n,
  input  logic             strap_half,
  output logic [N_CPU-1:0] cpu_clk,
  output logic [N_PCI-1:0] pci_clk,
  output logic             pci_free,
  output logic             aux_clk,
  output logic             cpu_running,
  output logic             pci_running
);

  localparam int CPU_CW = $clog2(CPU_HALF + 1);
  localparam int PCI_CW = $clog2(PCI_HALF + 1);
  localparam int AUX_CW = $clog2(2 * AUX_HALF + 1);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);

  // Power-down synchronizer and wake counter
  logic              pd1_q, pd2_q;
  logic [WAKE_W-1:0] wake_q, wake_d;
  logic              awake_q, awake_d;

  always_comb begin
    wake_d  = wake_q;
    awake_d = awake_q;
    if (!pd2_q) begin
      wake_d  = '0;
      awake_d = 1'b0;
    end else if (!awake_q) begin
      if (wake_q == WAKE_W'(WAKE_CYCLES - 1)) awake_d = 1'b1;
      else                                    wake_d  = wake_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd1_q   <= 1'b0;
      pd2_q   <= 1'b0;
      wake_q  <= '0;
      awake_q <= 1'b0;
    end else begin
      pd1_q   <= pwr_dn_n;
      pd2_q   <= pd1_q;
      wake_q  <= wake_d;
      awake_q <= awake_d;
    end
  end

  // One-shot strap capture
  logic sampled_q, strap_q, strap_d;

  always_comb strap_d = sampled_q ? strap_q : strap_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampled_q <= 1'b0;
      strap_q   <= 1'b0;
    end else begin
      sampled_q <= 1'b1;
      strap_q   <= strap_d;
    end
  end

  // Dividers
  logic cpu_ph, cpu_tick, pci_ph, pci_tick, aux_ph, aux_tick;
  logic [AUX_CW-1:0] aux_half_m1;

  assign aux_half_m1 = strap_q ? AUX_CW'(2 * AUX_HALF - 1) : AUX_CW'(AUX_HALF - 1);

  clkstop_div #(.CW(CPU_CW)) u_div_cpu (
    .clk(clk), .rst_n(rst_n), .run(1'b1), .half_m1(CPU_CW'(CPU_HALF - 1)),
    .phase_nx(cpu_ph), .rise_tick(cpu_tick));

  clkstop_div #(.CW(PCI_CW)) u_div_pci (
    .clk(clk), .rst_n(rst_n), .run(1'b1), .half_m1(PCI_CW'(PCI_HALF - 1)),
    .phase_nx(pci_ph), .rise_tick(pci_tick));

  clkstop_div #(.CW(AUX_CW)) u_div_aux (
    .clk(clk), .rst_n(rst_n), .run(sampled_q), .half_m1(aux_half_m1),
    .phase_nx(aux_ph), .rise_tick(aux_tick));

  // Gates
  logic free_run_unused, aux_run_unused;

  clkstop_gate #(.N(N_CPU)) u_gate_cpu (
    .clk(clk), .rst_n(rst_n), .rise_tick(cpu_tick), .phase_nx(cpu_ph),
    .run(awake_q && cpu_stop_n), .clk_o(cpu_clk), .running(cpu_running));

  clkstop_gate #(.N(N_PCI)) u_gate_pci (
    .clk(clk), .rst_n(rst_n), .rise_tick(pci_tick), .phase_nx(pci_ph),
    .run(awake_q && pci_stop_n), .clk_o(pci_clk), .running(pci_running));

  clkstop_gate #(.N(1)) u_gate_free (
    .clk(clk), .rst_n(rst_n), .rise_tick(pci_tick), .phase_nx(pci_ph),
    .run(awake_q), .clk_o(pci_free), .running(free_run_unused));

  clkstop_gate #(.N(1)) u_gate_aux (
    .clk(clk), .rst_n(rst_n), .rise_tick(aux_tick), .phase_nx(aux_ph),
    .run(awake_q && sampled_q), .clk_o(aux_clk), .running(aux_run_unused));

endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk #(
  parameter int N_CPU    = 4,
  parameter int N_PCI    = 7,
  parameter int CPU_HALF = 2,
  parameter int PCI_HALF = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_CPU-1:0] cpu_clk,
  input logic [N_PCI-1:0] pci_clk,
  input logic             pci_free,
  input logic             cpu_running,
  input logic             pci_running
);

  logic [15:0] cpu_hi, cpu_lo, pci_hi, pci_lo, free_hi;

  function automatic logic [15:0] bump(input logic [15:0] c);
    return (c == 16'hFFFF) ? c : c + 16'd1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_hi  <= '0;
      cpu_lo  <= '0;
      pci_hi  <= '0;
      pci_lo  <= '0;
      free_hi <= '0;
    end else begin
      cpu_hi  <= cpu_clk[0] ? bump(cpu_hi) : 16'd0;
      cpu_lo  <= cpu_clk[0] ? 16'd0 : bump(cpu_lo);
      pci_hi  <= pci_clk[0] ? bump(pci_hi) : 16'd0;
      pci_lo  <= pci_clk[0] ? 16'd0 : bump(pci_lo);
      free_hi <= pci_free ? bump(free_hi) : 16'd0;
    end
  end

  AST_CPU_HIGH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk[0]) |-> cpu_hi == 16'(CPU_HALF)); // R10
  AST_CPU_LOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk[0]) |-> cpu_lo >= 16'(CPU_HALF)); // R10
  AST_PCI_HIGH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pci_clk[0]) |-> pci_hi == 16'(PCI_HALF)); // R10
  AST_PCI_LOW_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_clk[0]) |-> pci_lo >= 16'(PCI_HALF)); // R10
  AST_FREE_HIGH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pci_free) |-> free_hi == 16'(PCI_HALF)); // R10
  AST_PCI_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pci_clk[0]) |-> $rose(pci_free)); // R5
  AST_CPU_GROUP_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk == '0) || (cpu_clk == '1)); // R2
  AST_CPU_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_running |-> cpu_clk == '0); // R11
  AST_PCI_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !pci_running |-> pci_clk == '0); // R11

endmodule

bind clkstop_ctrl clkstop_ctrl_chk #(
  .N_CPU(N_CPU), .N_PCI(N_PCI), .CPU_HALF(CPU_HALF), .PCI_HALF(PCI_HALF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_clk(cpu_clk), .pci_clk(pci_clk),
  .pci_free(pci_free), .cpu_running(cpu_running), .pci_running(pci_running)
);

// File: tb/test_clkstop_ctrl.sv
`timescale 1ns/1ps
module test_clkstop_ctrl;

  localparam int N_CPU = 4, N_PCI = 7;
  localparam int CPU_HALF = 2, PCI_HALF = 6, AUX_HALF = 3, WAKE = 40;
  localparam int CP = 2 * CPU_HALF;
  localparam int PP = 2 * PCI_HALF;

  logic clk = 1'b0;
  logic rst_n, cpu_stop_n, pci_stop_n, pwr_dn_n, strap_half;
  logic [N_CPU-1:0] cpu_clk;
  logic [N_PCI-1:0] pci_clk;
  logic pci_free, aux_clk, cpu_running, pci_running;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  clkstop_ctrl #(.N_CPU(N_CPU), .N_PCI(N_PCI), .CPU_HALF(CPU_HALF),
    .PCI_HALF(PCI_HALF), .AUX_HALF(AUX_HALF), .WAKE_CYCLES(WAKE)) i_clkstop_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
    .pwr_dn_n(pwr_dn_n), .strap_half(strap_half), .cpu_clk(cpu_clk),
    .pci_clk(pci_clk), .pci_free(pci_free), .aux_clk(aux_clk),
    .cpu_running(cpu_running), .pci_running(pci_running));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 cpu, 1 gated pci, 2 free pci, 3 aux, 4 any output
  function automatic logic sel(input int k);
    case (k)
      0: return cpu_clk[0];
      1: return pci_clk[0];
      2: return pci_free;
      3: return aux_clk;
      default: return (|cpu_clk) | (|pci_clk) | pci_free | aux_clk;
    endcase
  endfunction

  task automatic measure(input int k, output int hi, output int lo);
    int g;
    hi = 0; lo = 0; g = 0;
    while (sel(k) !== 1'b0 && g < 2000) begin @(negedge clk); g++; end
    while (sel(k) !== 1'b1 && g < 2000) begin @(negedge clk); g++; end
    while (sel(k) === 1'b1 && g < 2000) begin @(negedge clk); g++; hi++; end
    while (sel(k) === 1'b0 && g < 2000) begin @(negedge clk); g++; lo++; end
  endtask

  task automatic count_rises(input int k, input int ncyc, output int n);
    logic prev;
    n = 0;
    prev = sel(k);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (sel(k) && !prev) n++;
      prev = sel(k);
    end
  endtask

  task automatic cycles_to_rise(input int k, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!sel(k) && n < 2000);
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; cpu_stop_n = 1'b1; pci_stop_n = 1'b1; pwr_dn_n = 1'b1;
    strap_half = strap;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    int bad = 0, n;
    do_reset(1'b0);
    for (int i = 0; i < WAKE - 2; i++) begin
      @(negedge clk);
      if (sel(4) || cpu_running || pci_running) bad++;
    end
    check(bad == 0, "R1 outputs low during wake", bad, 0);
    cycles_to_rise(0, n);
    check(n <= 3 * CP + 8, "R1 cpu starts after wake", n, 3 * CP + 8);
    repeat (3 * PP) @(negedge clk);
    check(cpu_running && pci_running, "R11 running after start",
          {cpu_running, pci_running}, 3);
  endtask

  task automatic t_run;
    int hi, lo, bad = 0;
    measure(0, hi, lo);
    check(hi == CPU_HALF && lo == CPU_HALF, "R2 cpu waveform", hi * 100 + lo, CPU_HALF * 101);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cpu_clk != '0 && cpu_clk != '1) bad++;
    end
    check(bad == 0, "R2 cpu outputs identical", bad, 0);
    measure(1, hi, lo);
    check(hi == PCI_HALF && lo == PCI_HALF, "R5 pci waveform", hi * 100 + lo, PCI_HALF * 101);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pci_clk != {N_PCI{pci_free}}) bad++;
    end
    check(bad == 0, "R5 gated pci follows free pci", bad, 0);
    measure(3, hi, lo);
    check(hi == AUX_HALF && lo == AUX_HALF, "R9 aux full rate", hi * 100 + lo, AUX_HALF * 101);
  endtask

  task automatic t_cpu_stop;
    int n, bad = 0, hi, lo;
    @(negedge clk); cpu_stop_n = 1'b0;
    count_rises(0, 6 * CP, n);
    check(n == 2, "R3 two pulses after cpu stop", n, 2);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cpu_clk != '0) bad++;
    end
    check(bad == 0, "R3 cpu parked low", bad, 0);
    check(!cpu_running && pci_running, "R11 cpu status stopped", {cpu_running, pci_running}, 1);
    measure(1, hi, lo);
    check(hi == PCI_HALF, "R6 pci unaffected by cpu stop", hi, PCI_HALF);
    @(negedge clk); cpu_stop_n = 1'b1;
    cycles_to_rise(0, n);
    check(n >= 2 * CP && n <= 3 * CP, "R4 cpu restart latency", n, 3 * CP);
    hi = 0;
    while (cpu_clk[0] && hi < 100) begin @(negedge clk); hi++; end
    check(hi == CPU_HALF, "R4 first cpu phase full", hi, CPU_HALF);
    check(cpu_running, "R11 cpu status running", cpu_running, 1);
  endtask

  task automatic t_pci_stop;
    int n, nf, bad = 0;
    @(negedge clk); pci_stop_n = 1'b0;
    fork
      count_rises(1, 6 * PP, n);
      count_rises(2, 6 * PP, nf);
    join
    check(n == 2, "R5 two pulses after pci stop", n, 2);
    check(nf == 6, "R6 free pci keeps running", nf, 6);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pci_clk != '0) bad++;
    end
    check(bad == 0, "R5 gated pci parked low", bad, 0);
    check(!pci_running && cpu_running, "R11 pci status stopped", {cpu_running, pci_running}, 2);
    count_rises(0, 4 * CP, n);
    check(n == 4, "R6 cpu unaffected by pci stop", n, 4);
    @(negedge clk); pci_stop_n = 1'b1;
    cycles_to_rise(1, n);
    check(n >= 2 * PP && n <= 3 * PP, "R5 pci restart latency", n, 3 * PP);
    check(pci_free, "R5 restart aligned with free pci", pci_free, 1);
  endtask

  task automatic t_pwr;
    int n, bad = 0, hi, lo;
    @(negedge clk); pwr_dn_n = 1'b0;
    count_rises(0, 5 * PP, n);
    check(n >= 1, "R7 cpu completes a pulse before park", n, 1);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sel(4)) bad++;
    end
    check(bad == 0, "R7 all outputs held low", bad, 0);
    check(!cpu_running && !pci_running, "R7 status low in power-down",
          {cpu_running, pci_running}, 0);
    @(negedge clk); pwr_dn_n = 1'b1;
    cycles_to_rise(4, n);
    check(n >= WAKE && n <= WAKE + 3 * CP + 4, "R8 wake latency", n, WAKE);
    measure(0, hi, lo);
    check(hi == CPU_HALF && lo == CPU_HALF, "R8 full rate after wake", hi * 100 + lo, CPU_HALF * 101);
  endtask

  task automatic t_strap;
    int hi, lo, n;
    @(negedge clk); strap_half = 1'b1;
    repeat (10) @(negedge clk);
    measure(3, hi, lo);
    check(hi == AUX_HALF && lo == AUX_HALF, "R9 strap change ignored", hi * 100 + lo, AUX_HALF * 101);
    do_reset(1'b1);
    cycles_to_rise(3, n);
    measure(3, hi, lo);
    check(hi == 2 * AUX_HALF && lo == 2 * AUX_HALF, "R9 aux half rate",
          hi * 100 + lo, 2 * AUX_HALF * 101);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_run();
    t_cpu_stop();
    t_pci_stop();
    t_pwr();
    t_strap();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule